// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address for a synchronous burst memory. An access is opened by one of two active-low address strobes: one driven by a processor, one by a memory controller. When an access is accepted, the block captures the start address and then walks the two low address bits through a four-beat burst each time the step input is asserted. The upper address bits stay fixed for the whole burst.

Three chip selects gate every access. The processor strobe wins when both strobes arrive together. It is ignored outright when the first chip select is inactive. A strobe that is honoured while the chip selects do not all agree ends the current access. A static order input chooses between linear wrapping order and interleaved (XOR) order. All control and address inputs are sampled on the rising clock edge, so every effect appears at the outputs one cycle later.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted (rst_n low), mem_addr is 0, access_valid is 0 and start_by_ctl is 0.
- R2: A processor strobe (cpu_strobe_n low) with all chip selects active (cs0_n low, cs1 high, cs2_n low) loads addr_in into mem_addr and sets access_valid. It drives start_by_ctl to 0 at the next clock edge.
- R3: A controller strobe (ctl_strobe_n low) with the processor strobe not honoured and all chip selects active loads addr_in and sets access_valid. It drives start_by_ctl to 1 at the next edge.
- R4: When both strobes are low in the same cycle and cs0_n is low, only the processor strobe is honoured, so start_by_ctl becomes 0.
- R5: A processor strobe while cs0_n is high has no effect. With the controller strobe and step inactive, mem_addr and access_valid are unchanged at the next edge.
- R6: An honoured strobe while the chip selects are not all active clears access_valid at the next edge and leaves mem_addr unchanged.
- R7: With order_interleave low, the low two bits of mem_addr after n steps equal (start + n) mod 4.
- R8: With order_interleave high, the low two bits of mem_addr after n steps equal start XOR (n mod 4).
- R9: During a burst the upper 15 address bits never change. After four steps the address returns to the start address.
- R10: With no strobe honoured and step_n high, mem_addr holds its value.
- R11: Step requests while access_valid is low have no effect on mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 17 | Start address presented with a strobe |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, higher priority |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| cs0_n | input | 1 | First chip select, active low; also gates the processor strobe |
| cs1 | input | 1 | Second chip select, active high |
| cs2_n | input | 1 | Third chip select, active low |
| order_interleave | input | 1 | Burst order: 1 interleaved, 0 linear; held static |
| mem_addr | output | 17 | Current word address |
| access_valid | output | 1 | An access is open |
| start_by_ctl | output | 1 | The open access was started by the controller strobe |

## Verification
A wrong start-address register or wrong strobe priority shows up in the cycle right after the offending strobe: either mem_addr differs from the address presented or start_by_ctl has the wrong value. A wrong counter or order mix only shows up on the first step after a load. The most subtle case is the wrap: a counter that fails to return to zero after four steps first shows a wrong address on the fifth beat. So each burst is followed through eight steps in both orders, from every start offset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int BURST_W = 2;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_CTL = 1'b1
  } strobe_src_e;

  typedef struct packed {
    logic        load;
    logic        desel;
    strobe_src_e src;
  } strobe_dec_t;

  function automatic logic [BURST_W-1:0] linear_beat(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] beat
  );
    return base + beat;
  endfunction

  function automatic logic [BURST_W-1:0] interleave_beat(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] beat
  );
    return base ^ beat;
  endfunction

  function automatic logic [BURST_W-1:0] next_beat(
    input logic [BURST_W-1:0] beat
  );
    return beat + 1'b1;
  endfunction

endpackage

// File: rtl/bas_strobe_arb.sv
module bas_strobe_arb
  import burst_seq_pkg::*;
(
  input  logic        cpu_strobe_n,
  input  logic        ctl_strobe_n,
  input  logic        cs0_n,
  input  logic        cs1,
  input  logic        cs2_n,
  output strobe_dec_t dec
);

  logic cpu_take;
  logic ctl_take;
  logic any_take;
  logic all_sel;

  always_comb begin
    cpu_take = ~cpu_strobe_n & ~cs0_n;
    ctl_take = ~ctl_strobe_n & ~cpu_take;
    any_take = cpu_take | ctl_take;
    all_sel  = ~cs0_n & cs1 & ~cs2_n;
    dec.load  = any_take & all_sel;
    dec.desel = any_take & ~all_sel;
    dec.src   = ctl_take ? SRC_CTL : SRC_CPU;
  end

endmodule

// File: rtl/bas_wrap_cnt.sv
module bas_wrap_cnt
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = BURST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= next_beat(cnt_q);
    end
  end

endmodule

// File: rtl/bas_order_mix.sv
module bas_order_mix
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = BURST_W
) (
  input  logic [CNT_W-1:0] base,
  input  logic [CNT_W-1:0] beat,
  input  logic             interleave,
  output logic [CNT_W-1:0] low
);

  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign lin_low = linear_beat(base, beat);
  assign ilv_low = interleave_beat(base, beat);

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    assign low[b] = interleave ? ilv_low[b] : lin_low[b];
  end

endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = BURST_W,
  localparam int UP_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_dec_t       dec,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [UP_W-1:0]   upper_q,
  output logic [CNT_W-1:0]  base_q,
  output logic              valid_q,
  output logic              src_ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q   <= '0;
      base_q    <= '0;
      valid_q   <= 1'b0;
      src_ctl_q <= 1'b0;
    end else if (dec.load) begin
      upper_q   <= addr_in[ADDR_W-1:CNT_W];
      base_q    <= addr_in[CNT_W-1:0];
      valid_q   <= 1'b1;
      src_ctl_q <= (dec.src == SRC_CTL);
    end else if (dec.desel) begin
      valid_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  localparam int CNT_W = BURST_W,
  localparam int UP_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              step_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              order_interleave,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              access_valid,
  output logic              start_by_ctl
);

  strobe_dec_t      dec;
  logic [UP_W-1:0]  upper_q;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] low;
  logic             valid_q;
  logic             src_ctl_q;
  logic             order_q;

  // named internal events, used by the checker
  logic load_evt;
  logic desel_evt;
  logic step_evt;

  bas_strobe_arb u_arb (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .cs0_n        (cs0_n),
    .cs1          (cs1),
    .cs2_n        (cs2_n),
    .dec          (dec)
  );

  assign load_evt  = dec.load;
  assign desel_evt = dec.desel;
  assign step_evt  = valid_q & ~step_n & ~load_evt & ~desel_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 1'b1;
    end else begin
      order_q <= order_interleave;
    end
  end

  bas_addr_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_areg (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .addr_in   (addr_in),
    .upper_q   (upper_q),
    .base_q    (base_q),
    .valid_q   (valid_q),
    .src_ctl_q (src_ctl_q)
  );

  bas_wrap_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load_evt),
    .step  (step_evt),
    .cnt_q (cnt_q)
  );

  bas_order_mix #(.CNT_W(CNT_W)) u_mix (
    .base       (base_q),
    .beat       (cnt_q),
    .interleave (order_q),
    .low        (low)
  );

  assign mem_addr     = {upper_q, low};
  assign access_valid = valid_q;
  assign start_by_ctl = src_ctl_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              step_n,
  input logic              cs0_n,
  input logic              cs1,
  input logic              cs2_n,
  input logic              order_interleave,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              access_valid,
  input logic              start_by_ctl,
  input logic              load_evt,
  input logic [CNT_W-1:0]  cnt_q
);

  logic all_sel;
  logic cpu_hit;
  logic no_strobe;
  assign all_sel   = ~cs0_n & cs1 & ~cs2_n;
  assign cpu_hit   = ~cpu_strobe_n & ~cs0_n;
  assign no_strobe = cpu_strobe_n & ctl_strobe_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (mem_addr == '0 && !access_valid && !start_by_ctl); // R1
    end
  end

  AST_CPU_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && all_sel) |=> (mem_addr == $past(addr_in) && access_valid && !start_by_ctl)); // R2

  AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_strobe_n && !ctl_strobe_n && all_sel) |=> (mem_addr == $past(addr_in) && start_by_ctl)); // R3

  AST_CPU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && !ctl_strobe_n) |=> !start_by_ctl || !access_valid); // R4

  AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && cs0_n && ctl_strobe_n && step_n) |=> ($stable(mem_addr) && $stable(access_valid))); // R5

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_hit || !ctl_strobe_n) && !all_sel) |=> (!access_valid && $stable(mem_addr))); // R6

  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_q == '0); // R9

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !step_n && access_valid && !order_interleave && $stable(order_interleave))
    |=> mem_addr[CNT_W-1:0] == CNT_W'($past(mem_addr[CNT_W-1:0]) + 1'b1)); // R7

  AST_INTERLEAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !step_n && access_valid && order_interleave && $stable(order_interleave))
    |=> (mem_addr[CNT_W-1:0] ^ $past(mem_addr[CNT_W-1:0])) ==
        ($past(cnt_q) ^ CNT_W'($past(cnt_q) + 1'b1))); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    no_strobe |=> $stable(mem_addr[ADDR_W-1:CNT_W])); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && step_n && $stable(order_interleave)) |=> $stable(mem_addr)); // R10

  AST_STEP_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !access_valid && $stable(order_interleave)) |=> ($stable(mem_addr) && !access_valid)); // R11

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .addr_in          (addr_in),
  .cpu_strobe_n     (cpu_strobe_n),
  .ctl_strobe_n     (ctl_strobe_n),
  .step_n           (step_n),
  .cs0_n            (cs0_n),
  .cs1              (cs1),
  .cs2_n            (cs2_n),
  .order_interleave (order_interleave),
  .mem_addr         (mem_addr),
  .access_valid     (access_valid),
  .start_by_ctl     (start_by_ctl),
  .load_evt         (load_evt),
  .cnt_q            (cnt_q)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_strobe_n = 1'b1;
  logic          ctl_strobe_n = 1'b1;
  logic          step_n = 1'b1;
  logic          cs0_n = 1'b1;
  logic          cs1 = 1'b0;
  logic          cs2_n = 1'b1;
  logic          order_interleave = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          access_valid;
  logic          start_by_ctl;

  int n_checks = 0;
  int n_fail = 0;

  // bench reference state
  logic [AW-3:0] m_upper = '0;
  logic [1:0]    m_start = '0;
  int            m_beats = 0;
  logic          m_valid = 1'b0;
  logic          m_ctl = 1'b0;
  logic          m_order = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq u0 (
    .clk (clk), .rst_n (rst_n), .addr_in (addr_in),
    .cpu_strobe_n (cpu_strobe_n), .ctl_strobe_n (ctl_strobe_n),
    .step_n (step_n), .cs0_n (cs0_n), .cs1 (cs1), .cs2_n (cs2_n),
    .order_interleave (order_interleave),
    .mem_addr (mem_addr), .access_valid (access_valid),
    .start_by_ctl (start_by_ctl)
  );

  function automatic logic [AW-1:0] ref_addr();
    int lowv;
    if (m_order) lowv = int'(m_start) ^ (m_beats % 4);
    else         lowv = (int'(m_start) + m_beats) % 4;
    return {m_upper, 2'(lowv)};
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, mem_addr, ref_addr());
    chk(req, AW'(access_valid), AW'(m_valid));
    chk(req, AW'(start_by_ctl), AW'(m_ctl));
  endtask

  // one clock: drive at negedge, update the reference at the edge, compare at next negedge
  task automatic cycle(input string req, input logic [AW-1:0] a, input logic pn,
                       input logic cn, input logic sn, input logic [2:0] cs, input logic ord);
    logic sel_all, cpu_ok, evt;
    addr_in = a; cpu_strobe_n = pn; ctl_strobe_n = cn; step_n = sn;
    cs0_n = cs[0]; cs1 = cs[1]; cs2_n = cs[2]; order_interleave = ord;
    @(posedge clk);
    sel_all = !cs[0] && cs[1] && !cs[2];
    cpu_ok  = !pn && !cs[0];
    evt     = cpu_ok || !cn;
    if (evt && sel_all) begin
      m_upper = a[AW-1:2]; m_start = a[1:0]; m_beats = 0;
      m_valid = 1'b1; m_ctl = !cpu_ok;
    end else if (evt) begin
      m_valid = 1'b0;
    end else if (m_valid && !sn) begin
      m_beats = m_beats + 1;
    end
    m_order = ord;
    @(negedge clk);
    check_all(req);
  endtask

  localparam logic [2:0] SEL = 3'b010; // cs2_n=0, cs1=1, cs0_n=0

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // exhaustive strobe x chip-select sweep (R2 R3 R4 R5 R6)
    for (int cs = 0; cs < 8; cs++) begin
      for (int st = 0; st < 4; st++) begin
        cycle("R2", 17'h1A5C6, 1'b0, 1'b1, 1'b1, SEL, 1'b1);
        if (st == 0)               cycle("R4", AW'(cs * 977 + 3), 1'b0, 1'b0, 1'b1, 3'(cs), 1'b1);
        else if (st == 1)          cycle(3'(cs) == SEL ? "R2" : (cs[0] ? "R5" : "R6"),
                                         AW'(cs * 531 + 1), 1'b0, 1'b1, 1'b1, 3'(cs), 1'b1);
        else if (st == 2)          cycle(3'(cs) == SEL ? "R3" : "R6",
                                         AW'(cs * 211 + 2), 1'b1, 1'b0, 1'b1, 3'(cs), 1'b1);
        else                       cycle("R10", AW'(cs * 4099), 1'b1, 1'b1, 1'b1, 3'(cs), 1'b1);
        cycle("R10", 17'h0F0F0, 1'b1, 1'b1, 1'b1, 3'(cs), 1'b1);
      end
    end

    // bursts in both orders from every start offset (R7 R8 R9)
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 3; u++) begin
          logic [AW-1:0] base;
          base = {15'(u * 12345 + 7), 2'(s)};
          cycle("R10", '0, 1'b1, 1'b1, 1'b1, SEL, 1'(ord));
          cycle(u == 1 ? "R3" : "R2", base, u == 1, 1'b0, 1'b1, SEL, 1'(ord));
          for (int k = 0; k < 8; k++) begin
            cycle(ord != 0 ? "R8" : "R7", AW'(k * 333), 1'b1, 1'b1, 1'b0, 3'(k), 1'(ord));
            if (k == 3) chk("R9", mem_addr, base);
            if (k == 5) cycle("R10", '1, 1'b1, 1'b1, 1'b1, SEL, 1'(ord));
          end
          chk("R9", mem_addr, {base[AW-1:2], ord != 0 ? (2'(s) ^ 2'd0) : 2'(s)});
        end
      end
    end

    // steps while no access is open (R11)
    cycle("R2", 17'h05557, 1'b0, 1'b1, 1'b1, SEL, 1'b0);
    cycle("R7", '0, 1'b1, 1'b1, 1'b0, SEL, 1'b0);
    cycle("R6", 17'h1FFFF, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0);
    for (int k = 0; k < 5; k++) cycle("R11", AW'(k), 1'b1, 1'b1, 1'b0, SEL, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule